// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Unit

This block keeps a full set of traffic counters for every port of a small switch. The MAC side delivers one-cycle event strobes per port (broadcast, multicast, pause, FCS errors, frame-size buckets, collisions and the like) and three length-qualified byte events per port. Each event strobe feeds a saturating 32-bit counter. Each byte event feeds a saturating 64-bit accumulator. Software never reads the live counters. It reads a snapshot bank that the block fills on command.

Software drives the block through a single 32-bit control register. A 3-bit function code starts one of two sequenced operations. A capture copies every live counter of every port into the snapshot bank. A flush zeroes both the live counters and the snapshot. The sequencer has three states. IDLE leaves IDLE on a capture code (the IDLE to CAPTURE transition) or on a flush code (the IDLE to FLUSH transition). In CAPTURE or FLUSH the sequencer walks the ports and counters, one counter per clock cycle. Once the last counter is handled, it takes the CAPTURE to IDLE or the FLUSH to IDLE transition. A busy flag is high for the whole walk. The control register also holds a global count enable, a 16-bit timer value and an at-half capture enable, which are kept for software.

Top module: `stat_counter_unit`

## Requirements
- R1: After reset, the control register reads 0 and every snapshot word of every port reads 0.
- R2: The control register (default address 0x80) stores timer bits 15:0, the at-half enable at bit 16 and the count enable at bit 30, and reads them back. All other bits read 0 except the busy flag (bit 17) and the function field (bits 26:24). The function field reads 0 whenever the block is idle.
- R3: Writing function code 3 captures. Afterwards every counter word reads the value its live counter held when the walk reached it. Later events do not change what software reads until the next capture.
- R4: Writing function code 1 flushes. Afterwards every live counter and every snapshot word of every port is 0.
- R5: Once a capture or flush is accepted, the busy flag is 1 for exactly NUM_PORTS*39 cycles, one per counter. While busy, the function field reads the code that is running.
- R6: A control write that arrives while busy is ignored as a whole. The running operation, the stored timer, the at-half bit and the count enable are all left unchanged.
- R7: While the count enable is 0, no counter changes on any event.
- R8: Counters saturate at all-ones and never wrap.
- R9: A byte event adds its length to the matching 64-bit counter. The low 32 bits read at the counter's offset and the high 32 bits at offset+4. Byte counter 0 sits at 0x3C, byte counter 1 at 0x44 and byte counter 2 at 0x84.
- R10: Port p's bank starts at 0x20000 + p*0x100. Strobe bit e of a port counts into word offset e for e<=14, e+4 for 15<=e<=28, and e+6 for 29<=e<=35. Strobe bit e of port p is input bit p*36+e.
- R11: Reads of unused words inside a bank (offsets 0xA8 to 0xFC), of banks for ports at or above NUM_PORTS, and of any other unmapped address return 0.
- R12: An event that arrives in the same cycle as its own counter is flushed is lost. An event in the next cycle is counted. The walk goes in port-major order, counter index minor, starting at port 0 counter 0 in the cycle after the command write.
- R13: Function codes other than 1 and 3 start nothing, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ev_stb | input | NUM_PORTS*36 | Per-port single-count event strobes |
| by_vld | input | NUM_PORTS*3 | Per-port byte event valid |
| by_len | input | NUM_PORTS*3*LEN_W | Byte counts for the byte events |

## Verification
The bench measures the exact length of the busy window and checks the function field while the walk runs. A design whose walk is off by one would miss the last counter or hold busy one cycle too long. It writes a flush in the middle of a capture. A design that accepted that write would zero the snapshot or overwrite the timer. It drives a strobe into port 0's first counter in the very cycle that counter is cleared, and again one cycle later. A wrong priority or a wrong walk order would change that count. The bench also forces saturation with narrow event counters, pushes a byte counter past 2^32 to expose a missing carry into the high word, and sweeps every bank word, including unused offsets and an absent port, against a model of the offset layout.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int EV_CNT  = 36;
    localparam int BY_CNT  = 3;
    localparam int CTR_CNT = EV_CNT + BY_CNT;

    localparam logic [2:0] FN_NOP     = 3'd0;
    localparam logic [2:0] FN_FLUSH   = 3'd1;
    localparam logic [2:0] FN_CAPTURE = 3'd3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CAPTURE,
        S_FLUSH
    } seq_state_t;

    typedef struct packed {
        logic       vld;
        logic       is_byte;
        logic [5:0] idx;
        logic       hi;
    } word_map_t;

    // word offset within a port bank -> counter selector
    function automatic word_map_t map_word(input logic [5:0] w);
        word_map_t m;
        m = '0;
        if (w <= 6'd14) begin
            m.vld = 1'b1;
            m.idx = w;
        end else if (w <= 6'd18) begin
            m.vld     = 1'b1;
            m.is_byte = 1'b1;
            m.idx     = (w - 6'd15) >> 1;
            m.hi      = ~w[0];
        end else if (w <= 6'd32) begin
            m.vld = 1'b1;
            m.idx = w - 6'd4;
        end else if (w <= 6'd34) begin
            m.vld     = 1'b1;
            m.is_byte = 1'b1;
            m.idx     = 6'd2;
            m.hi      = (w == 6'd34);
        end else if (w <= 6'd41) begin
            m.vld = 1'b1;
            m.idx = w - 6'd6;
        end
        return m;
    endfunction

endpackage

// File: rtl/stat_cmd_seq.sv
module stat_cmd_seq
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 3,
    parameter int CTR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    output logic              busy,
    output logic              cap_go,
    output logic              flush_go,
    output logic [PORT_W-1:0] walk_port,
    output logic [CTR_W-1:0]  walk_ctr,
    output logic              cnt_en,
    output logic              half_en,
    output logic [15:0]       timer_q,
    output logic [2:0]        func_q
);

    localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);
    localparam logic [CTR_W-1:0]  LAST_CTR  = CTR_W'(CTR_CNT - 1);

    seq_state_t state, nxt;
    logic       walk_last;
    logic [2:0] wfunc;
    logic       accept;

    assign wfunc     = ctl_wdata[26:24];
    assign walk_last = (walk_port == LAST_PORT) && (walk_ctr == LAST_CTR);
    assign accept    = ctl_wr && (state == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept && wfunc == FN_CAPTURE)    nxt = S_CAPTURE;
                else if (accept && wfunc == FN_FLUSH) nxt = S_FLUSH;
            end
            S_CAPTURE: if (walk_last) nxt = S_IDLE;
            S_FLUSH:   if (walk_last) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        cap_go   = 1'b0;
        flush_go = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_CAPTURE: begin busy = 1'b1; cap_go   = 1'b1; end
            S_FLUSH:   begin busy = 1'b1; flush_go = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_port <= '0;
            walk_ctr  <= '0;
        end else if (state == S_IDLE) begin
            walk_port <= '0;
            walk_ctr  <= '0;
        end else if (walk_ctr == LAST_CTR) begin
            walk_ctr  <= '0;
            walk_port <= walk_port + 1'b1;
        end else begin
            walk_ctr  <= walk_ctr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en  <= 1'b0;
            half_en <= 1'b0;
            timer_q <= '0;
        end else if (accept) begin
            cnt_en  <= ctl_wdata[30];
            half_en <= ctl_wdata[16];
            timer_q <= ctl_wdata[15:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= FN_NOP;
        end else if (accept && (wfunc == FN_CAPTURE || wfunc == FN_FLUSH)) begin
            func_q <= wfunc;
        end else if (state != S_IDLE && walk_last) begin
            func_q <= FN_NOP;
        end
    end

endmodule

// File: rtl/stat_live_bank.sv
module stat_live_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int EV_W      = 32,
    parameter int BY_W      = 64,
    parameter int LEN_W     = 16,
    parameter int PORT_W    = 3,
    parameter int CTR_W     = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cnt_en,
    input  logic                           flush_go,
    input  logic [PORT_W-1:0]              walk_port,
    input  logic [CTR_W-1:0]               walk_ctr,
    input  logic [NUM_PORTS*EV_CNT-1:0]    ev_stb,
    input  logic [NUM_PORTS*BY_CNT-1:0]    by_vld,
    input  logic [NUM_PORTS*BY_CNT*LEN_W-1:0] by_len,
    output logic [BY_W-1:0]                sel_val
);

    logic [EV_W-1:0] ev_arr [NUM_PORTS][EV_CNT];
    logic [BY_W-1:0] by_arr [NUM_PORTS][BY_CNT];

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        for (genvar ge = 0; ge < EV_CNT; ge++) begin : g_ev
            logic [EV_W-1:0] cnt_q;
            logic            clr;
            assign clr = flush_go && (walk_port == PORT_W'(gp)) && (walk_ctr == CTR_W'(ge));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (clr)
                    cnt_q <= '0;
                else if (cnt_en && ev_stb[gp*EV_CNT+ge] && cnt_q != '1)
                    cnt_q <= cnt_q + 1'b1;
            end
            assign ev_arr[gp][ge] = cnt_q;
        end
        for (genvar gb = 0; gb < BY_CNT; gb++) begin : g_by
            logic [BY_W-1:0] acc_q;
            logic [BY_W:0]   sum;
            logic            clr;
            assign clr = flush_go && (walk_port == PORT_W'(gp)) &&
                         (walk_ctr == CTR_W'(EV_CNT + gb));
            assign sum = {1'b0, acc_q} +
                         {{(BY_W+1-LEN_W){1'b0}}, by_len[(gp*BY_CNT+gb)*LEN_W +: LEN_W]};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    acc_q <= '0;
                else if (clr)
                    acc_q <= '0;
                else if (cnt_en && by_vld[gp*BY_CNT+gb])
                    acc_q <= sum[BY_W] ? '1 : sum[BY_W-1:0];
            end
            assign by_arr[gp][gb] = acc_q;
        end
    end

    always_comb begin
        sel_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int c = 0; c < EV_CNT; c++)
                if (walk_port == PORT_W'(p) && walk_ctr == CTR_W'(c))
                    sel_val = BY_W'(ev_arr[p][c]);
            for (int b = 0; b < BY_CNT; b++)
                if (walk_port == PORT_W'(p) && walk_ctr == CTR_W'(EV_CNT + b))
                    sel_val = by_arr[p][b];
        end
    end

endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int EV_W      = 32,
    parameter int BY_W      = 64,
    parameter int PORT_W    = 3,
    parameter int CTR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_go,
    input  logic              flush_go,
    input  logic [PORT_W-1:0] walk_port,
    input  logic [CTR_W-1:0]  walk_ctr,
    input  logic [BY_W-1:0]   sel_val,
    input  logic [7:0]        rd_port,
    input  logic [5:0]        rd_word,
    output logic [31:0]       rd_val
);

    logic [EV_W-1:0] snap_ev [NUM_PORTS][EV_CNT];
    logic [BY_W-1:0] snap_by [NUM_PORTS][BY_CNT];

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        for (genvar gc = 0; gc < CTR_CNT; gc++) begin : g_ctr
            localparam int VW = (gc < EV_CNT) ? EV_W : BY_W;
            logic [VW-1:0] snap_q;
            logic          hit;
            assign hit = (walk_port == PORT_W'(gp)) && (walk_ctr == CTR_W'(gc));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    snap_q <= '0;
                else if (flush_go && hit)
                    snap_q <= '0;
                else if (cap_go && hit)
                    snap_q <= sel_val[VW-1:0];
            end
            if (gc < EV_CNT) begin : g_e
                assign snap_ev[gp][gc] = snap_q;
            end else begin : g_b
                assign snap_by[gp][gc-EV_CNT] = snap_q;
            end
        end
    end

    word_map_t   m;
    logic [63:0] val64;

    assign m = map_word(rd_word);

    always_comb begin
        val64 = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == 8'(p)) begin
                for (int e = 0; e < EV_CNT; e++)
                    if (!m.is_byte && m.idx == 6'(e))
                        val64 = 64'(snap_ev[p][e]);
                for (int b = 0; b < BY_CNT; b++)
                    if (m.is_byte && m.idx == 6'(b))
                        val64 = 64'(snap_by[p][b]);
            end
        end
        if (!m.vld)
            rd_val = '0;
        else if (m.hi)
            rd_val = val64[63:32];
        else
            rd_val = val64[31:0];
    end

endmodule

// File: rtl/stat_counter_unit.sv
module stat_counter_unit
    import stat_pkg::*;
#(
    parameter int          NUM_PORTS = 5,
    parameter int          EV_W      = 32,
    parameter int          BY_W      = 64,
    parameter int          LEN_W     = 16,
    parameter int          ADDR_W    = 18,
    parameter logic [17:0] CTRL_ADDR = 18'h00080
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    input  logic [NUM_PORTS*EV_CNT-1:0]       ev_stb,
    input  logic [NUM_PORTS*BY_CNT-1:0]       by_vld,
    input  logic [NUM_PORTS*BY_CNT*LEN_W-1:0] by_len
);

    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CTR_W    = $clog2(CTR_CNT);
    localparam int WALK_LEN = NUM_PORTS * CTR_CNT;

    logic              ctl_wr;
    logic              bank_hit;
    logic              busy;
    logic              cap_go;
    logic              flush_go;
    logic [PORT_W-1:0] walk_port;
    logic [CTR_W-1:0]  walk_ctr;
    logic              cnt_en;
    logic              half_en;
    logic [15:0]       timer_q;
    logic [2:0]        func_q;
    logic [BY_W-1:0]   sel_val;
    logic [31:0]       snap_rd;
    logic [31:0]       ctl_rd;

    assign ctl_wr   = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
    assign bank_hit = (reg_addr >> 16) == ADDR_W'(2);

    stat_cmd_seq #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .CTR_W     (CTR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (reg_wdata),
        .busy      (busy),
        .cap_go    (cap_go),
        .flush_go  (flush_go),
        .walk_port (walk_port),
        .walk_ctr  (walk_ctr),
        .cnt_en    (cnt_en),
        .half_en   (half_en),
        .timer_q   (timer_q),
        .func_q    (func_q)
    );

    stat_live_bank #(
        .NUM_PORTS (NUM_PORTS),
        .EV_W      (EV_W),
        .BY_W      (BY_W),
        .LEN_W     (LEN_W),
        .PORT_W    (PORT_W),
        .CTR_W     (CTR_W)
    ) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .flush_go  (flush_go),
        .walk_port (walk_port),
        .walk_ctr  (walk_ctr),
        .ev_stb    (ev_stb),
        .by_vld    (by_vld),
        .by_len    (by_len),
        .sel_val   (sel_val)
    );

    stat_snap_bank #(
        .NUM_PORTS (NUM_PORTS),
        .EV_W      (EV_W),
        .BY_W      (BY_W),
        .PORT_W    (PORT_W),
        .CTR_W     (CTR_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_go    (cap_go),
        .flush_go  (flush_go),
        .walk_port (walk_port),
        .walk_ctr  (walk_ctr),
        .sel_val   (sel_val),
        .rd_port   (reg_addr[15:8]),
        .rd_word   (reg_addr[7:2]),
        .rd_val    (snap_rd)
    );

    assign ctl_rd = {1'b0, cnt_en, 3'b000, func_q, 6'b000000, busy, half_en, timer_q};

    always_comb begin
        if (reg_addr == ADDR_W'(CTRL_ADDR))
            reg_rdata = ctl_rd;
        else if (bank_hit)
            reg_rdata = snap_rd;
        else
            reg_rdata = '0;
    end

endmodule

// File: rtl/stat_counter_chk.sv
module stat_counter_chk #(
    parameter int WALK_LEN = 195
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ctl_wr,
    input logic [2:0]  wr_func,
    input logic [15:0] timer_q,
    input logic        en_q,
    input logic [2:0]  func_q,
    input logic        cap_go,
    input logic        flush_go
);

    logic [15:0] span;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    span <= '0;
        else if (busy) span <= span + 1'b1;
        else           span <= '0;
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (span == 16'(WALK_LEN))); // R5

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (span < 16'(WALK_LEN))); // R5

    AST_BUSY_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (func_q == 3'd1 || func_q == 3'd3)); // R5

    AST_FUNC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (func_q == 3'd0)); // R2

    AST_LOCKED_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> ($stable(timer_q) && $stable(en_q))); // R6

    AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_go, flush_go})); // R13

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ctl_wr) && ($past(wr_func) == 3'd1 || $past(wr_func) == 3'd3))); // R13

endmodule

bind stat_counter_unit stat_counter_chk #(.WALK_LEN(NUM_PORTS * stat_pkg::CTR_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ctl_wr   (ctl_wr),
    .wr_func  (reg_wdata[26:24]),
    .timer_q  (timer_q),
    .en_q     (cnt_en),
    .func_q   (func_q),
    .cap_go   (cap_go),
    .flush_go (flush_go)
);

// File: tb/sim_stat_counter_unit.sv
`timescale 1ns/1ps
module sim_stat_counter_unit;

    localparam int NP   = 5;
    localparam int EVW  = 8;
    localparam int BYW  = 64;
    localparam int LW   = 24;
    localparam int NE   = 36;
    localparam int NB   = 3;
    localparam int WALK = NP * (NE + NB);
    localparam logic [17:0] CTRL = 18'h00080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                 reg_we = 1'b0;
    logic [17:0]          reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [NP*NE-1:0]     ev_stb = '0;
    logic [NP*NB-1:0]     by_vld = '0;
    logic [NP*NB*LW-1:0]  by_len = '0;

    stat_counter_unit #(
        .NUM_PORTS (NP), .EV_W (EVW), .BY_W (BYW), .LEN_W (LW), .ADDR_W (18), .CTRL_ADDR (CTRL)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .ev_stb (ev_stb), .by_vld (by_vld), .by_len (by_len)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    int unsigned      m_ev [NP][NE];
    int unsigned      s_ev [NP][NE];
    longint unsigned  m_by [NP][NB];
    longint unsigned  s_by [NP][NB];
    bit               en_m = 1'b0;
    bit               half_m = 1'b0;
    bit [15:0]        tim_m = '0;

    task automatic chk(input string req, input longint unsigned got, input longint unsigned exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ctl_exp(input bit bsy, input logic [2:0] fn);
        return {1'b0, en_m, 3'b000, fn, 6'b000000, bsy, half_m, tim_m};
    endfunction

    // expected snapshot word per the R10/R9/R11 layout
    function automatic logic [31:0] exp_word(input int p, input int w);
        longint unsigned v;
        if (p >= NP) return '0;
        if (w <= 14)      return s_ev[p][w];
        else if (w <= 18) begin v = s_by[p][(w-15)/2]; return (w % 2 == 0) ? v[63:32] : v[31:0]; end
        else if (w <= 32) return s_ev[p][w-4];
        else if (w <= 34) begin v = s_by[p][2]; return (w == 34) ? v[63:32] : v[31:0]; end
        else if (w <= 41) return s_ev[p][w-6];
        return '0;
    endfunction

    task automatic rd(input logic [17:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl_word(input logic [2:0] fn);
        logic [31:0] d;
        d = '0;
        d[30] = en_m; d[26:24] = fn; d[16] = half_m; d[15:0] = tim_m;
        return d;
    endfunction

    task automatic model_cmd(input logic [2:0] fn);
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) begin
                if (fn == 3'd1) begin m_ev[p][e] = 0; s_ev[p][e] = 0; end
                else s_ev[p][e] = m_ev[p][e];
            end
            for (int b = 0; b < NB; b++) begin
                if (fn == 3'd1) begin m_by[p][b] = 0; s_by[p][b] = 0; end
                else s_by[p][b] = m_by[p][b];
            end
        end
    endtask

    // issue command, measure busy length (R5)
    task automatic do_cmd(input logic [2:0] fn);
        int n;
        wr(CTRL, ctl_word(fn));
        #0.5;
        n = 0;
        while (reg_rdata[17] && n < 2 * WALK) begin
            n++;
            @(negedge clk);
            #0.5;
        end
        chk("R5 busy length", n, WALK);
        chk("R2 func reads 0 when idle", reg_rdata[26:24], 0);
        model_cmd(fn);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int p = 0; p <= NP; p++)
            for (int w = 0; w < 64; w++) begin
                rd(18'h20000 + 18'(p * 256 + w * 4), d);
                chk(tag, d, exp_word(p, w));
            end
    endtask

    task automatic model_step();
        if (!en_m) return;
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++)
                if (ev_stb[p*NE+e] && m_ev[p][e] < 255) m_ev[p][e]++;
            for (int b = 0; b < NB; b++)
                if (by_vld[p*NB+b]) m_by[p][b] += longint'(by_len[(p*NB+b)*LW +: LW]);
        end
    endtask

    task automatic traffic(input int n, input int dens);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int k = 0; k < NP*NE; k++) ev_stb[k] = ($urandom % 100) < dens;
            for (int k = 0; k < NP*NB; k++) begin
                by_vld[k] = ($urandom % 100) < dens;
                by_len[k*LW +: LW] = LW'($urandom & 32'hFFF);
            end
            @(posedge clk);
            model_step();
        end
        @(negedge clk);
        ev_stb = '0; by_vld = '0; by_len = '0;
    endtask

    task automatic pulse(input int bit_ev, input int bit_by, input logic [LW-1:0] len, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bit_ev >= 0) ev_stb[bit_ev] = 1'b1;
            if (bit_by >= 0) begin by_vld[bit_by] = 1'b1; by_len[bit_by*LW +: LW] = len; end
            @(posedge clk);
            model_step();
        end
        @(negedge clk);
        ev_stb = '0; by_vld = '0; by_len = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED1234));
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) begin m_ev[p][e] = 0; s_ev[p][e] = 0; end
            for (int b = 0; b < NB; b++) begin m_by[p][b] = 0; s_by[p][b] = 0; end
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(CTRL, d);
        chk("R1 control after reset", d, 0);
        check_all("R1 snapshot after reset");

        // R2 control fields, undefined bits dropped
        en_m = 1'b1; half_m = 1'b1; tim_m = 16'hBEEF;
        wr(CTRL, ctl_word(3'd0) | 32'h8000_0020);
        rd(CTRL, d);
        chk("R2 control readback", d, ctl_exp(1'b0, 3'd0));

        // R13 unused code starts nothing
        wr(CTRL, ctl_word(3'd2));
        #0.5;
        chk("R13 code 2 leaves busy low", reg_rdata[17], 0);
        wr(CTRL, ctl_word(3'd7));
        #0.5;
        chk("R13 code 7 leaves busy low", reg_rdata[17], 0);

        // R3 R9 R10 random traffic then capture
        traffic(300, 20);
        do_cmd(3'd3);
        check_all("R3 R10 R11 capture after random traffic");

        // R3 snapshot holds while live counters move
        traffic(100, 40);
        check_all("R3 snapshot stable without capture");
        do_cmd(3'd3);
        check_all("R3 second capture");

        // R6 write during busy is ignored
        tim_m = 16'h1234;
        wr(CTRL, ctl_word(3'd3));
        rd(CTRL, d);
        chk("R5 busy and func while capturing", d, ctl_exp(1'b1, 3'd3));
        wr(CTRL, 32'h0100_AAAA);
        for (int i = 0; i < 2 * WALK; i++) begin
            rd(CTRL, d);
            if (!d[17]) break;
        end
        chk("R6 control unchanged after ignored write", d, ctl_exp(1'b0, 3'd0));
        model_cmd(3'd3);
        check_all("R6 snapshot not flushed");

        // R7 disabled counting
        en_m = 1'b0;
        wr(CTRL, ctl_word(3'd0));
        traffic(80, 50);
        do_cmd(3'd3);
        check_all("R7 no change while disabled");
        en_m = 1'b1;
        wr(CTRL, ctl_word(3'd0));

        // R8 saturation of event counter port 1 event 7
        pulse(1*NE + 7, -1, '0, 300);
        // R9 carry into high word, port 2 byte counter 0
        pulse(-1, 2*NB + 0, 24'hFF_FFFF, 300);
        do_cmd(3'd3);
        rd(18'h20000 + 18'h100 + 18'h1C, d);
        chk("R8 saturated counter", d, 255);
        rd(18'h20000 + 18'h200 + 18'h40, d);
        chk("R9 byte counter high word", d, exp_word(2, 16));
        check_all("R8 R9 full sweep");

        // R11 unmapped addresses
        rd(18'h30000, d);
        chk("R11 unmapped region", d, 0);
        rd(18'h00084, d);
        chk("R11 unmapped low address", d, 0);
        rd(18'h20000 + 18'h700, d);
        chk("R11 absent port bank", d, 0);

        // R4 flush
        do_cmd(3'd1);
        check_all("R4 snapshot after flush");
        do_cmd(3'd3);
        check_all("R4 live after flush");

        // R12 strobe in same cycle as clear is lost
        pulse(0, -1, '0, 5);
        wr(CTRL, ctl_word(3'd1));
        ev_stb[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ev_stb[0] = 1'b0;
        repeat (WALK + 2) @(negedge clk);
        model_cmd(3'd1);
        do_cmd(3'd3);
        rd(18'h20000, d);
        chk("R12 strobe during own clear dropped", d, 0);

        // R12 strobe one cycle later counts
        wr(CTRL, ctl_word(3'd1));
        @(posedge clk);
        @(negedge clk);
        ev_stb[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ev_stb[0] = 1'b0;
        repeat (WALK + 2) @(negedge clk);
        model_cmd(3'd1);
        m_ev[0][0] = 1;
        do_cmd(3'd3);
        rd(18'h20000, d);
        chk("R12 strobe after clear counted", d, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule